// File: doc/BRIEF.md
# Commit-Stage Indirect Edge Verifier

This block sits at the front of the commit stage and checks the control-flow edge of every indirect instruction (return, indirect call) as it commits. It presents the full-width source PC and the resolved target to an external edge cache in the same cycle. It then decides the outcome from the cache's hit answer and from whether the resolved target matches the predicted one.

- A verified edge commits normally. If the prediction was wrong, fetch is redirected to the resolved target.
- An edge that cannot be verified is treated like a mispredict. Younger work is squashed and fetch is redirected to the fall-through address where the backing branch sled begins.

After a failed verification, the block holds one pending edge record containing the offending source PC. The first taken direct branch that commits afterwards is the sled's choice. That branch's target completes the pair, and the block writes the pair into the cache with a single-cycle insert pulse. Because commit is in order, only one such record is ever in flight.

Top module: `edge_commit_verifier`

## Requirements
- R1: When `cmt_valid` and `cmt_indirect` are both 1, `ec_lookup_valid` is 1 in the same cycle, with `ec_lookup_src` equal to `cmt_pc` and `ec_lookup_tgt` equal to `cmt_target`. Otherwise `ec_lookup_valid` is 0.
- R2: On a lookup that hits (`ec_hit`=1) with `cmt_target` equal to `cmt_pred_target`, `edge_ok` is 1 and both `squash` and `redirect_valid` are 0 in that cycle.
- R3: On a lookup that hits with `cmt_target` different from `cmt_pred_target` in any of the AW bits (including the top bit), `edge_ok` is 1, `squash` and `redirect_valid` are 1, and `redirect_pc` equals `cmt_target`.
- R4: On a lookup that misses (`ec_hit`=0), whether the prediction was right or wrong, `edge_ok` is 0, `squash` and `redirect_valid` are 1, and `redirect_pc` equals `cmt_sled_pc`.
- R5: `squash`, `redirect_valid` and `edge_ok` are 0 in every cycle without a lookup. This includes cycles where `cmt_indirect` is 1 but `cmt_valid` is 0, and valid non-indirect commits.
- R6: A missing lookup arms a pending record holding `cmt_pc`. In the next cycle after a later commit with `cmt_valid`=1, `cmt_indirect`=0 and `cmt_branch_taken`=1, `ec_fill_valid` is 1 with `ec_fill_src` equal to the armed PC and `ec_fill_tgt` equal to that branch's `cmt_target`. That branch disarms the record.
- R7: No fill is produced by the following: a taken branch while nothing is armed; a not-taken commit; or a cycle with `cmt_valid`=0. The last two leave an armed record intact.
- R8: A second miss while a record is armed replaces the armed source PC, so the later fill carries the newest source.
- R9: `ec_fill_valid` is a single-cycle pulse. Reset (`rst_n`=0) clears the armed record and the fill output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_indirect | input | 1 | The committing instruction is an indirect branch |
| cmt_branch_taken | input | 1 | The committing instruction is a taken direct branch |
| cmt_pc | input | AW | PC of the committing instruction |
| cmt_target | input | AW | Resolved target of the committing instruction |
| cmt_pred_target | input | AW | Predicted target of the committing indirect instruction |
| cmt_sled_pc | input | AW | Fall-through address of the first sled instruction |
| ec_lookup_valid | output | 1 | Edge cache query strobe |
| ec_lookup_src | output | AW | Query source address |
| ec_lookup_tgt | output | AW | Query target address |
| ec_hit | input | 1 | Edge cache answer for the current query |
| edge_ok | output | 1 | Edge verified; the instruction may commit |
| squash | output | 1 | Discard all younger instructions |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | AW | Fetch redirect address |
| ec_fill_valid | output | 1 | Edge cache insert pulse |
| ec_fill_src | output | AW | Inserted source address |
| ec_fill_tgt | output | AW | Inserted target address |

## Verification
The bench drives a correctly predicted indirect branch whose cache lookup misses. A design that only checked mispredicted branches would let that edge commit without a squash. It also drives a hit whose resolved target differs from the prediction only in the top bit; a truncated compare would miss that redirect. Between arming and closing a sled, it inserts not-taken commits and invalid taken-branch cycles: a design that closed on any commit would write a wrong target. Further cases cover a taken branch with nothing armed, a double miss (the stale source must not be inserted), and reset in mid-sled (which must drop the record rather than fill it later).

// File: rtl/edge_commit_verifier.sv
module edge_commit_verifier #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmt_valid,
  input  logic          cmt_indirect,
  input  logic          cmt_branch_taken,
  input  logic [AW-1:0] cmt_pc,
  input  logic [AW-1:0] cmt_target,
  input  logic [AW-1:0] cmt_pred_target,
  input  logic [AW-1:0] cmt_sled_pc,
  output logic          ec_lookup_valid,
  output logic [AW-1:0] ec_lookup_src,
  output logic [AW-1:0] ec_lookup_tgt,
  input  logic          ec_hit,
  output logic          edge_ok,
  output logic          squash,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          ec_fill_valid,
  output logic [AW-1:0] ec_fill_src,
  output logic [AW-1:0] ec_fill_tgt
);

  logic          probe;
  logic          wrong_guess;
  logic          fail;
  logic          sled_done;
  logic          armed_q;
  logic [AW-1:0] armed_src_q;

  assign probe       = cmt_valid & cmt_indirect;
  assign wrong_guess = cmt_target != cmt_pred_target;
  assign fail        = probe & ~ec_hit;
  assign sled_done   = cmt_valid & ~cmt_indirect & cmt_branch_taken & armed_q;

  assign ec_lookup_valid = probe;
  assign ec_lookup_src   = cmt_pc;
  assign ec_lookup_tgt   = cmt_target;

  assign edge_ok        = probe & ec_hit;
  assign squash         = fail | (edge_ok & wrong_guess);
  assign redirect_valid = squash;
  assign redirect_pc    = ec_hit ? cmt_target : cmt_sled_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q       <= 1'b0;
      armed_src_q   <= '0;
      ec_fill_valid <= 1'b0;
      ec_fill_src   <= '0;
      ec_fill_tgt   <= '0;
    end else begin
      ec_fill_valid <= sled_done;
      if (sled_done) begin
        ec_fill_src <= armed_src_q;
        ec_fill_tgt <= cmt_target;
      end
      if (fail) begin
        armed_q     <= 1'b1;
        armed_src_q <= cmt_pc;
      end else if (sled_done) begin
        armed_q <= 1'b0;
      end
    end
  end

endmodule

module edge_commit_verifier_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmt_valid,
  input logic          cmt_indirect,
  input logic          cmt_branch_taken,
  input logic [AW-1:0] cmt_pc,
  input logic [AW-1:0] cmt_target,
  input logic [AW-1:0] cmt_pred_target,
  input logic [AW-1:0] cmt_sled_pc,
  input logic          ec_lookup_valid,
  input logic          ec_hit,
  input logic          edge_ok,
  input logic          squash,
  input logic          redirect_valid,
  input logic [AW-1:0] redirect_pc,
  input logic          ec_fill_valid,
  input logic [AW-1:0] ec_fill_src,
  input logic [AW-1:0] ec_fill_tgt
);

  logic          sh_armed;
  logic [AW-1:0] sh_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_armed <= 1'b0;
      sh_src   <= '0;
    end else if (ec_lookup_valid && !ec_hit) begin
      sh_armed <= 1'b1;
      sh_src   <= cmt_pc;
    end else if (cmt_valid && !cmt_indirect && cmt_branch_taken) begin
      sh_armed <= 1'b0;
    end
  end

  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ec_lookup_valid && ec_hit && cmt_target == cmt_pred_target) |-> (edge_ok && !squash && !redirect_valid));

  a_r3_hit_fixup: assert property (@(posedge clk) disable iff (!rst_n)
    (ec_lookup_valid && ec_hit && cmt_target != cmt_pred_target) |-> (squash && redirect_valid && redirect_pc == cmt_target));

  a_r4_miss_to_sled: assert property (@(posedge clk) disable iff (!rst_n)
    (ec_lookup_valid && !ec_hit) |-> (squash && redirect_valid && !edge_ok && redirect_pc == cmt_sled_pc));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmt_valid && cmt_indirect) |-> (!squash && !redirect_valid && !edge_ok));

  a_r6_fill_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ec_fill_valid |-> (ec_fill_src == $past(sh_src) && ec_fill_tgt == $past(cmt_target)));

  a_r7_fill_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ec_fill_valid |-> $past(sh_armed));

  a_r9_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ec_fill_valid |=> !ec_fill_valid);

endmodule

bind edge_commit_verifier edge_commit_verifier_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_indirect(cmt_indirect),
  .cmt_branch_taken(cmt_branch_taken), .cmt_pc(cmt_pc), .cmt_target(cmt_target),
  .cmt_pred_target(cmt_pred_target), .cmt_sled_pc(cmt_sled_pc),
  .ec_lookup_valid(ec_lookup_valid), .ec_hit(ec_hit), .edge_ok(edge_ok),
  .squash(squash), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .ec_fill_valid(ec_fill_valid), .ec_fill_src(ec_fill_src), .ec_fill_tgt(ec_fill_tgt)
);

// File: tb/edge_commit_verifier_tb.sv
module edge_commit_verifier_tb;
  localparam int AW = 64;

  typedef struct packed {
    logic          ind;
    logic          hit;
    logic [AW-1:0] pc;
    logic [AW-1:0] tgt;
    logic [AW-1:0] pred;
    logic [AW-1:0] sled;
    logic          esq;
    logic          eok;
    logic [AW-1:0] erpc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 64'h1000, 64'h2000, 64'h2000, 64'h9000, 1'b0, 1'b1, 64'h0},
    '{1'b1, 1'b1, 64'h1010, 64'h2100, 64'h2200, 64'h9100, 1'b1, 1'b1, 64'h2100},
    '{1'b1, 1'b0, 64'h1020, 64'h2300, 64'h2300, 64'h9200, 1'b1, 1'b0, 64'h9200},
    '{1'b1, 1'b0, 64'h1030, 64'h2400, 64'h2500, 64'h9300, 1'b1, 1'b0, 64'h9300},
    '{1'b0, 1'b1, 64'h1040, 64'h2600, 64'h2600, 64'h9400, 1'b0, 1'b0, 64'h0},
    '{1'b1, 1'b1, 64'h1050, 64'h8000_0000_0000_2700, 64'h2700, 64'h9500, 1'b1, 1'b1, 64'h8000_0000_0000_2700}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmt_valid = 1'b0, cmt_indirect = 1'b0, cmt_branch_taken = 1'b0, ec_hit = 1'b0;
  logic [AW-1:0] cmt_pc = '0, cmt_target = '0, cmt_pred_target = '0, cmt_sled_pc = '0;
  logic          ec_lookup_valid, edge_ok, squash, redirect_valid, ec_fill_valid;
  logic [AW-1:0] ec_lookup_src, ec_lookup_tgt, redirect_pc, ec_fill_src, ec_fill_tgt;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  edge_commit_verifier #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_indirect(cmt_indirect),
    .cmt_branch_taken(cmt_branch_taken), .cmt_pc(cmt_pc), .cmt_target(cmt_target),
    .cmt_pred_target(cmt_pred_target), .cmt_sled_pc(cmt_sled_pc),
    .ec_lookup_valid(ec_lookup_valid), .ec_lookup_src(ec_lookup_src), .ec_lookup_tgt(ec_lookup_tgt),
    .ec_hit(ec_hit), .edge_ok(edge_ok), .squash(squash), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .ec_fill_valid(ec_fill_valid), .ec_fill_src(ec_fill_src),
    .ec_fill_tgt(ec_fill_tgt)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic ind, input logic tk, input logic hit,
                       input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                       input logic [AW-1:0] pred, input logic [AW-1:0] sled);
    cmt_valid = v; cmt_indirect = ind; cmt_branch_taken = tk; ec_hit = hit;
    cmt_pc = pc; cmt_target = tgt; cmt_pred_target = pred; cmt_sled_pc = sled;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=<5000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset fill", {63'b0, ec_fill_valid}, 64'd0);
    chk("R5 reset squash", {63'b0, squash}, 64'd0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, TBL[i].ind, 1'b0, TBL[i].hit, TBL[i].pc, TBL[i].tgt, TBL[i].pred, TBL[i].sled);
      chk("R1 lookup valid", {63'b0, ec_lookup_valid}, {63'b0, TBL[i].ind});
      if (TBL[i].ind) begin
        chk("R1 lookup src", ec_lookup_src, TBL[i].pc);
        chk("R1 lookup tgt", ec_lookup_tgt, TBL[i].tgt);
      end
      chk("R2 R3 R4 edge_ok", {63'b0, edge_ok}, {63'b0, TBL[i].eok});
      chk("R2 R3 R4 R5 squash", {63'b0, squash}, {63'b0, TBL[i].esq});
      chk("R2 R3 R4 R5 redirect_valid", {63'b0, redirect_valid}, {63'b0, TBL[i].esq});
      if (TBL[i].esq) chk("R3 R4 redirect_pc", redirect_pc, TBL[i].erpc);
      step();
    end

    // R5: indirect flag without valid commit
    drive(1'b0, 1'b1, 1'b0, 1'b0, 64'h1111, 64'h2222, 64'h3333, 64'h4444);
    chk("R5 invalid no squash", {63'b0, squash}, 64'd0);
    chk("R5 invalid no lookup", {63'b0, ec_lookup_valid}, 64'd0);

    // fresh start for pending tests
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    step();
    rst_n = 1'b1;

    // R7: taken branch with nothing armed
    drive(1'b1, 1'b0, 1'b1, 1'b0, 64'h500, 64'h600, '0, '0);
    step();
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    chk("R7 unarmed no fill", {63'b0, ec_fill_valid}, 64'd0);

    // R6: miss arms, then filler cycles, then taken branch closes
    drive(1'b1, 1'b1, 1'b0, 1'b0, 64'hA000, 64'hB000, 64'hB000, 64'hC000);
    step();
    drive(1'b1, 1'b0, 1'b0, 1'b0, 64'hC000, 64'hC004, '0, '0);
    step();
    drive(1'b0, 1'b0, 1'b1, 1'b0, 64'hC004, 64'hDEAD, '0, '0);
    step();
    chk("R7 not-taken/invalid no fill", {63'b0, ec_fill_valid}, 64'd0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 64'hC008, 64'hB100, '0, '0);
    step();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 64'hB100, 64'hE000, '0, '0);
    chk("R6 fill valid", {63'b0, ec_fill_valid}, 64'd1);
    chk("R6 fill src", ec_fill_src, 64'hA000);
    chk("R6 fill tgt", ec_fill_tgt, 64'hB100);
    step();
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    chk("R9 fill single pulse / R6 disarmed", {63'b0, ec_fill_valid}, 64'd0);

    // R8: two misses, newest source wins
    drive(1'b1, 1'b1, 1'b0, 1'b0, 64'hA100, 64'hB200, 64'hB300, 64'hC100);
    step();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 64'hA200, 64'hB400, 64'hB400, 64'hC200);
    step();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 64'hC200, 64'hB500, '0, '0);
    step();
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    chk("R8 fill valid", {63'b0, ec_fill_valid}, 64'd1);
    chk("R8 newest src", ec_fill_src, 64'hA200);
    chk("R8 fill tgt", ec_fill_tgt, 64'hB500);
    step();

    // R9: reset mid-sled drops the record
    drive(1'b1, 1'b1, 1'b0, 1'b0, 64'hA300, 64'hB600, 64'hB600, 64'hC300);
    step();
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    step();
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 1'b1, 1'b0, 64'hC300, 64'hB700, '0, '0);
    step();
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    chk("R9 reset clears pending", {63'b0, ec_fill_valid}, 64'd0);

    step();
    finish_run();
  end
endmodule